// File: doc/BRIEF.md
# Floating-Point Exception Flag Accumulator

This block sits beside a floating-point unit and turns each operation's raw status report into sticky exception flags held in a small control/status register. Every time the unit strobes a status vector, the block decodes the individual causes into eight flags. It ORs them into the register, but only while the register's exception-enable bit is 1. Software can rewrite the whole register at any time, and this is the only way, apart from reset, to clear a flag.

After each strobe that is accepted, the block checks whether any of the eight flags is now set. If so, it raises a single-cycle request toward the exception controller. Several invalid-operation causes fold into one invalid flag. The two infinity-arithmetic causes also raise a separate infinity flag, and the two NaN causes each raise a dedicated NaN flag as well.

Top module: `fpx_flag_accum`

## Requirements
- R1: While the enable bit (register bit 0) is 0, a status strobe changes no register bit and produces no request.
- R2: Any of the nine invalid causes (cause bits 0 to 8: signalling NaN, quiet NaN, inf-inf, inf/inf, 0/0, inf*0, bad conversion, bad compare, bad square root) sets the invalid flag at register bit 1.
- R3: Cause bit 0 (signalling NaN) also sets register bit 2, and cause bit 1 (quiet NaN) also sets register bit 3, in addition to the invalid flag.
- R4: Cause bits 9, 10, 11 and 12 set register bits 4 (overflow), 5 (underflow), 7 (divide by zero) and 8 (inexact), respectively.
- R5: Cause bit 2 (inf-inf) or cause bit 3 (inf/inf) sets the infinity flag at register bit 6 as well as the invalid flag.
- R6: The request is high for exactly the one cycle after an accepted strobe that leaves any of register bits 8..1 set, including flags set earlier. It stays low after an accepted strobe that leaves all eight flags clear.
- R7: Flags are sticky: once set, a flag stays 1 until reset or a software write.
- R8: A software write loads the enable bit and all flags from the write data, visible the next cycle. When a write and a strobe occur in the same cycle, the written enable bit decides whether the strobe is accepted, and newly decoded flags are ORed onto the written flags.
- R9: Reset clears the register and the request.
- R10: Register bits above bit 8 always read 0; written values there are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fpu_st_valid | input | 1 | Status vector strobe from the floating-point unit |
| fpu_st_cause | input | 13 | Per-operation cause bits, one per condition |
| csr_wr | input | 1 | Software write strobe |
| csr_wdata | input | REG_W | Software write data |
| csr_q | output | REG_W | Register contents: bit 0 enable, bits 8..1 flags |
| fpe_req | output | 1 | One-cycle exception request |

## Verification
A corrupted flag or enable bit is visible on `csr_q` in the cycle after it goes wrong. Because flags are sticky, it stays visible until the next software write, so a wrong decode shows up as a wrong bit pattern against the expected cause mapping. A wrong enable or an incorrect pulse rule shows on `fpe_req` one cycle after the strobe: either a missing pulse, a pulse while disabled, or a pulse that lasts past a single cycle. The write-and-strobe collision cases separate a design that gates with the old enable from one that gates with the newly written enable.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
   // cause vector positions
   localparam int CAUSE_W     = 13;
   localparam int C_SNAN      = 0;
   localparam int C_QNAN      = 1;
   localparam int C_INF_SUB   = 2;
   localparam int C_INF_DIV   = 3;
   localparam int C_ZERO_DIV0 = 4;
   localparam int C_INF_MUL0  = 5;
   localparam int C_CONV      = 6;
   localparam int C_CMP       = 7;
   localparam int C_SQRT      = 8;
   localparam int C_OVF       = 9;
   localparam int C_UNF       = 10;
   localparam int C_DZ        = 11;
   localparam int C_INEXACT   = 12;
   localparam int N_INVALID   = 9;

   // flag vector positions (register bit = FLAG_LSB + index)
   localparam int FLAG_N   = 8;
   localparam int EN_BIT   = 0;
   localparam int FLAG_LSB = 1;
   localparam int F_INV    = 0;
   localparam int F_SNAN   = 1;
   localparam int F_QNAN   = 2;
   localparam int F_OVF    = 3;
   localparam int F_UNF    = 4;
   localparam int F_INF    = 5;
   localparam int F_DZ     = 6;
   localparam int F_IX     = 7;
   localparam int USED_W   = FLAG_LSB + FLAG_N;

   typedef logic [FLAG_N-1:0]  flag_vec_t;
   typedef logic [CAUSE_W-1:0] cause_vec_t;
endpackage

// File: rtl/fpx_cause_decode.sv
module fpx_cause_decode
   import fpx_pkg::*;
(
   input  cause_vec_t cause,
   output flag_vec_t  flags
);
   logic any_invalid;

   always_comb begin
      any_invalid = 1'b0;
      for (int i = 0; i < N_INVALID; i++) begin
         any_invalid = any_invalid | cause[i];
      end
   end

   always_comb begin
      flags         = '0;
      flags[F_INV]  = any_invalid;
      flags[F_SNAN] = cause[C_SNAN];
      flags[F_QNAN] = cause[C_QNAN];
      flags[F_OVF]  = cause[C_OVF];
      flags[F_UNF]  = cause[C_UNF];
      flags[F_INF]  = cause[C_INF_SUB] | cause[C_INF_DIV];
      flags[F_DZ]   = cause[C_DZ];
      flags[F_IX]   = cause[C_INEXACT];
   end
endmodule

// File: rtl/fpx_flag_store.sv
module fpx_flag_store
   import fpx_pkg::*;
#(
   parameter int REG_W = 12
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_wr,
   input  logic [REG_W-1:0] sw_wdata,
   input  logic             upd_valid,
   input  flag_vec_t        upd_flags,
   output logic [REG_W-1:0] csr_q,
   output logic             upd_hit
);
   logic      en_q;
   logic      en_base;
   logic      gate;
   flag_vec_t flag_q;
   flag_vec_t flag_base;
   flag_vec_t flag_d;

   assign en_base = sw_wr ? sw_wdata[EN_BIT] : en_q;
   assign gate    = upd_valid & en_base;

   for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
      assign flag_base[g] = sw_wr ? sw_wdata[FLAG_LSB+g] : flag_q[g];
      assign flag_d[g]    = flag_base[g] | (gate & upd_flags[g]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         flag_q <= '0;
      end else begin
         en_q   <= en_base;
         flag_q <= flag_d;
      end
   end

   assign upd_hit = gate & (|flag_d);

   if (REG_W > USED_W) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^sw_wdata[REG_W-1:USED_W];
      assign csr_q     = {{(REG_W-USED_W){1'b0}}, flag_q, en_q};
   end else begin : g_exact
      assign csr_q = {flag_q, en_q};
   end
endmodule

// File: rtl/fpx_req_pulse.sv
module fpx_req_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   output logic req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req <= 1'b0;
      else        req <= hit;
   end
endmodule

// File: rtl/fpx_flag_accum.sv
module fpx_flag_accum
   import fpx_pkg::*;
#(
   parameter int REG_W = 12
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fpu_st_valid,
   input  logic [CAUSE_W-1:0] fpu_st_cause,
   input  logic               csr_wr,
   input  logic [REG_W-1:0]   csr_wdata,
   output logic [REG_W-1:0]   csr_q,
   output logic               fpe_req
);
   if (REG_W < USED_W) begin : g_bad_width
      $error("fpx_flag_accum: REG_W must hold the enable bit and eight flags");
   end

   flag_vec_t dec_flags;
   logic      hit;

   fpx_cause_decode u_dec (
      .cause (fpu_st_cause),
      .flags (dec_flags)
   );

   fpx_flag_store #(.REG_W(REG_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_wr     (csr_wr),
      .sw_wdata  (csr_wdata),
      .upd_valid (fpu_st_valid),
      .upd_flags (dec_flags),
      .csr_q     (csr_q),
      .upd_hit   (hit)
   );

   fpx_req_pulse u_req (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit),
      .req   (fpe_req)
   );
endmodule

// File: rtl/fpx_flag_accum_chk.sv
module fpx_flag_accum_chk
   import fpx_pkg::*;
#(
   parameter int REG_W = 12
)(
   input logic               clk,
   input logic               rst_n,
   input logic               fpu_st_valid,
   input logic [CAUSE_W-1:0] fpu_st_cause,
   input logic               csr_wr,
   input logic [REG_W-1:0]   csr_wdata,
   input logic [REG_W-1:0]   csr_q,
   input logic               fpe_req
);
   logic [FLAG_N-1:0] flg;
   logic              next_en;
   assign flg     = csr_q[FLAG_LSB +: FLAG_N];
   assign next_en = csr_wr ? csr_wdata[EN_BIT] : csr_q[EN_BIT];

   AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (fpu_st_valid && !csr_wr && !csr_q[EN_BIT]) |=> ($stable(csr_q) && !fpe_req)); // R1
   AST_SNAN_SETS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      (fpu_st_valid && fpu_st_cause[C_SNAN] && next_en) |=> (flg[F_SNAN] && flg[F_INV])); // R3
   AST_REQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      fpe_req |-> (csr_q[EN_BIT] && (flg != '0))); // R6
   AST_REQ_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      fpe_req |-> $past(fpu_st_valid)); // R6
   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !csr_wr |=> ((flg & $past(flg)) == $past(flg))); // R7
   AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_q >> USED_W) == '0); // R10
endmodule

bind fpx_flag_accum fpx_flag_accum_chk #(.REG_W(REG_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .fpu_st_valid (fpu_st_valid),
   .fpu_st_cause (fpu_st_cause),
   .csr_wr       (csr_wr),
   .csr_wdata    (csr_wdata),
   .csr_q        (csr_q),
   .fpe_req      (fpe_req)
);

// File: tb/fpx_flag_accum_bench.sv
module fpx_flag_accum_bench;
   localparam int CLK_PERIOD = 10;
   localparam int REG_W      = 12;
   localparam int NV         = 36;

   // {wr, wdata[11:0], valid, cause[12:0], exp_csr[11:0], exp_req}
   localparam logic [39:0] VEC [NV] = '{
      {1'b0,12'h000,1'b1,13'h0001,12'h000,1'b0}, // 0
      {1'b1,12'h001,1'b0,13'h0000,12'h001,1'b0}, // 1
      {1'b0,12'h000,1'b1,13'h0000,12'h001,1'b0}, // 2
      {1'b0,12'h000,1'b1,13'h0010,12'h003,1'b1}, // 3
      {1'b0,12'h000,1'b0,13'h0000,12'h003,1'b0}, // 4
      {1'b1,12'h001,1'b0,13'h0000,12'h001,1'b0}, // 5
      {1'b0,12'h000,1'b1,13'h0001,12'h007,1'b1}, // 6
      {1'b1,12'h001,1'b0,13'h0000,12'h001,1'b0}, // 7
      {1'b0,12'h000,1'b1,13'h0002,12'h00B,1'b1}, // 8
      {1'b1,12'h001,1'b0,13'h0000,12'h001,1'b0}, // 9
      {1'b0,12'h000,1'b1,13'h0004,12'h043,1'b1}, // 10
      {1'b1,12'h001,1'b0,13'h0000,12'h001,1'b0}, // 11
      {1'b0,12'h000,1'b1,13'h0008,12'h043,1'b1}, // 12
      {1'b1,12'h001,1'b0,13'h0000,12'h001,1'b0}, // 13
      {1'b0,12'h000,1'b1,13'h0200,12'h011,1'b1}, // 14
      {1'b0,12'h000,1'b1,13'h0400,12'h031,1'b1}, // 15
      {1'b0,12'h000,1'b1,13'h0800,12'h0B1,1'b1}, // 16
      {1'b0,12'h000,1'b1,13'h1000,12'h1B1,1'b1}, // 17
      {1'b0,12'h000,1'b1,13'h0000,12'h1B1,1'b1}, // 18
      {1'b1,12'h000,1'b0,13'h0000,12'h000,1'b0}, // 19
      {1'b1,12'h001,1'b1,13'h0020,12'h003,1'b1}, // 20
      {1'b1,12'h000,1'b1,13'h0040,12'h000,1'b0}, // 21
      {1'b1,12'hFFF,1'b0,13'h0000,12'h1FF,1'b0}, // 22
      {1'b0,12'h000,1'b1,13'h0080,12'h1FF,1'b1}, // 23
      {1'b1,12'h1FE,1'b0,13'h0000,12'h1FE,1'b0}, // 24
      {1'b0,12'h000,1'b1,13'h0100,12'h1FE,1'b0}, // 25
      {1'b1,12'h001,1'b0,13'h0000,12'h001,1'b0}, // 26
      {1'b0,12'h000,1'b1,13'h0100,12'h003,1'b1}, // 27
      {1'b1,12'h001,1'b0,13'h0000,12'h001,1'b0}, // 28
      {1'b0,12'h000,1'b1,13'h0040,12'h003,1'b1}, // 29
      {1'b1,12'h001,1'b0,13'h0000,12'h001,1'b0}, // 30
      {1'b0,12'h000,1'b1,13'h0020,12'h003,1'b1}, // 31
      {1'b1,12'h001,1'b0,13'h0000,12'h001,1'b0}, // 32
      {1'b0,12'h000,1'b1,13'h0080,12'h003,1'b1}, // 33
      {1'b1,12'h001,1'b0,13'h0000,12'h001,1'b0}, // 34
      {1'b0,12'h000,1'b1,13'h1E01,12'h1B7,1'b1}  // 35
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             fpu_st_valid = 1'b0;
   logic [12:0]      fpu_st_cause = '0;
   logic             csr_wr = 1'b0;
   logic [REG_W-1:0] csr_wdata = '0;
   logic [REG_W-1:0] csr_q;
   logic             fpe_req;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpx_flag_accum #(.REG_W(REG_W)) u_fpx_flag_accum (
      .clk          (clk),
      .rst_n        (rst_n),
      .fpu_st_valid (fpu_st_valid),
      .fpu_st_cause (fpu_st_cause),
      .csr_wr       (csr_wr),
      .csr_wdata    (csr_wdata),
      .csr_q        (csr_q),
      .fpe_req      (fpe_req)
   );

   function automatic string tag_of(int i);
      case (i)
         0, 25:                  return "R1";
         3, 27, 29, 31, 33:      return "R2";
         6, 8, 35:               return "R3";
         14, 16, 17:             return "R4";
         10, 12:                 return "R5";
         2, 4, 18:               return "R6";
         15, 23:                 return "R7";
         22:                     return "R10";
         default:                return "R8";
      endcase
   endfunction

   task automatic check(string tag, logic [REG_W-1:0] exp_csr, logic exp_req);
      total++;
      if (csr_q !== exp_csr || fpe_req !== exp_req) begin
         bad++;
         $display("FAIL %s: csr_q=%h fpe_req=%b expected csr_q=%h fpe_req=%b",
                  tag, csr_q, fpe_req, exp_csr, exp_req);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R9", '0, 1'b0);              // R9 state during reset
      rst_n = 1'b1;
      @(negedge clk);
      check("R9", '0, 1'b0);              // R9 state after release
      for (int i = 0; i < NV; i++) begin
         csr_wr       = VEC[i][39];
         csr_wdata    = VEC[i][38:27];
         fpu_st_valid = VEC[i][26];
         fpu_st_cause = VEC[i][25:13];
         @(negedge clk);
         check(tag_of(i), VEC[i][12:1], VEC[i][0]);
      end
      csr_wr = 1'b0; fpu_st_valid = 1'b0; fpu_st_cause = '0; csr_wdata = '0;
      @(negedge clk);
      check("R6", 12'h1B7, 1'b0);          // R6 pulse ends, R7 flags held
      rst_n = 1'b0;
      #1;
      check("R9", '0, 1'b0);              // R9 asynchronous clear mid-run
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9", '0, 1'b0);
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule